// File: doc/BRIEF.md
# Echo Canceller Group Register Space and Power-Up Sequencer

This block holds the host-visible register space for a bank of sixteen echo canceller groups, each made of two channels (an A canceller on the even channel, a B canceller on the odd one). A byte-wide host bus with address, write strobe, read strobe and data reaches every group's per-channel register bytes. It also reaches one main control byte per group, an interrupt FIFO byte and a test byte. Reads are combinational. The data bus and interrupt line are driven only through output enables, and both enables are dropped while reset is held low.

Bit 0 of a group's main control byte is its power-up bit. When the host moves that bit from zero to one, the group alone starts a background initialization. For one cycle it raises that group's coefficient-clear output. It then refills the group's 64 register bytes with their defaults through a shared write port, and it stays busy until the second frame strobe after the edge. While a group is busy, the host cannot change its channel bytes and reads of them return the defaults. The other groups keep working normally. Several groups may initialize at the same time. A fixed-priority arbiter, lowest group first, shares the single write port among them.

Top module: `ecg_init_ctrl`

## Requirements
- R1: Address map. Group g, channel half h (0 = A, 1 = B) and byte offset o (0..31) sit at address g*64 + h*32 + o. Main control byte g sits at 0x400+g. The interrupt FIFO byte is at 0x410 and the test byte at 0x411. Writes to 0x412 and above change nothing, and reads there return 0x00.
- R2: After reset, all main control bytes, the FIFO byte and the test byte read 0x00. The busy and coef_clr vectors are all zero.
- R3: While rst_n is low, rdata_oe and irq_oe are both low. Once rst_n is high, irq_oe is high and rdata_oe follows rd_en.
- R4: irq is high exactly when the interrupt FIFO byte is nonzero.
- R5: A write that sets bit 0 of main control byte g while that bit was 0 raises busy[g] and coef_clr[g] from the write's clock edge. coef_clr[g] lasts exactly one cycle. Other groups' busy and coef_clr bits are unaffected.
- R6: busy[g] clears on the clock edge that samples the second frame_pulse after the power-up edge, and at no other time.
- R7: After initialization, each group byte holds its default. Per-channel offset 0 holds 0x01, offset 1 holds 0x04, and every other offset holds 0x00.
- R8: While busy[g] is high, host writes to group g's channel bytes are ignored, and reads of them return the defaults of R7.
- R9: Writing 1 to a power-up bit that is already 1 starts nothing. Clearing the bit leaves the group's bytes and its busy state unchanged.
- R10: A new power-up rising edge while busy restarts the two-frame count from zero.
- R11: When several groups power up together, every one of them ends with all its bytes at their defaults.
- R12: A channel byte of an idle group reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; powers the bus outputs down |
| frame_pulse | input | 1 | One-cycle strobe per frame |
| addr | input | 16 | Host byte address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational) |
| rdata_oe | output | 1 | Output enable for rdata |
| irq | output | 1 | Interrupt request |
| irq_oe | output | 1 | Output enable for irq |
| coef_clr | output | 16 | Per-group coefficient-clear pulse |
| busy | output | 16 | Per-group initialization in progress |

## Verification
The bench goes after the edge cases of the power-up bit. These are a repeated write of 1, a fall to 0 followed by a new rise inside the busy window, and all sixteen groups rising at once. A design that detected levels instead of edges would pulse coef_clr again. One that ignored the restart would drop busy one frame early, and one with a broken arbiter would leave bytes of the lower-priority groups stale. Random traffic writes idle and busy groups alike, so a design that let host writes through during initialization, or that served stored bytes instead of defaults, shows a miscompare on read-back. Reserved addresses and reset-time output enables are checked directly.

// File: rtl/ecg_pkg.sv
package ecg_pkg;
    localparam int N_GRP    = 16;
    localparam int CH_BYTES = 32;
    localparam int AW       = 16;

    // Default content of a channel byte, by its offset within the channel.
    function automatic logic [7:0] def_byte(input int unsigned off, input int unsigned ch_bytes);
        case (off % ch_bytes)
            0:       return 8'h01;
            1:       return 8'h04;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ecg_grp_seq.sv
module ecg_grp_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic pw_rise,
    input  logic frame_pulse,
    output logic busy,
    output logic coef_clr
);
    typedef struct packed {
        logic busy;
        logic fseen;
        logic clr;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d     = q;
        d.clr = 1'b0;
        if (pw_rise) begin
            d.busy  = 1'b1;
            d.fseen = 1'b0;
            d.clr   = 1'b1;
        end else if (q.busy && frame_pulse) begin
            if (q.fseen) begin
                d.busy  = 1'b0;
                d.fseen = 1'b0;
            end else begin
                d.fseen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign coef_clr = q.clr;

    a_r5_clr_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        coef_clr |-> busy);
    a_r5_clr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        coef_clr |=> !coef_clr);
    a_r6_busy_ends_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frame_pulse));
endmodule

// File: rtl/ecg_fill_arb.sv
module ecg_fill_arb #(
    parameter int N_GRP    = ecg_pkg::N_GRP,
    parameter int CH_BYTES = ecg_pkg::CH_BYTES,
    localparam int GRP_BYTES = 2 * CH_BYTES,
    localparam int GW = $clog2(N_GRP),
    localparam int OW = $clog2(GRP_BYTES),
    localparam int MW = GW + OW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_GRP-1:0] pw_rise,
    input  logic             stall,
    output logic             fill_we,
    output logic [MW-1:0]    fill_addr,
    output logic [7:0]       fill_data
);
    typedef struct packed {
        logic [N_GRP-1:0]         pend;
        logic [N_GRP-1:0][OW-1:0] cnt;
    } arb_t;

    arb_t q, d;
    logic [N_GRP-1:0] grant;
    logic [GW-1:0]    sel;
    logic             found;

    always_comb begin
        grant = '0;
        sel   = '0;
        found = 1'b0;
        for (int g = 0; g < N_GRP; g++) begin
            if (q.pend[g] && !found) begin
                grant[g] = 1'b1;
                sel      = GW'(g);
                found    = 1'b1;
            end
        end
        fill_we   = found && !stall;
        fill_addr = {sel, q.cnt[sel]};
        fill_data = ecg_pkg::def_byte(int'(q.cnt[sel]), CH_BYTES);

        d = q;
        for (int g = 0; g < N_GRP; g++) begin
            if (pw_rise[g]) begin
                d.pend[g] = 1'b1;
                d.cnt[g]  = '0;
            end else if (grant[g] && !stall) begin
                d.cnt[g] = q.cnt[g] + 1'b1;
                if (q.cnt[g] == '1) d.pend[g] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/ecg_reg_bank.sv
module ecg_reg_bank #(
    parameter int N_GRP    = ecg_pkg::N_GRP,
    parameter int CH_BYTES = ecg_pkg::CH_BYTES,
    parameter int AW       = ecg_pkg::AW,
    localparam int GRP_BYTES = 2 * CH_BYTES,
    localparam int SPAN      = N_GRP * GRP_BYTES,
    localparam int GW = $clog2(N_GRP),
    localparam int OW = $clog2(GRP_BYTES),
    localparam int MW = GW + OW,
    localparam int MAIN_BASE = SPAN,
    localparam int FIFO_ADDR = SPAN + N_GRP,
    localparam int TEST_ADDR = SPAN + N_GRP + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic [N_GRP-1:0] busy,
    input  logic             fill_we,
    input  logic [MW-1:0]    fill_addr,
    input  logic [7:0]       fill_data,
    output logic [7:0]       rdata,
    output logic             host_chan_wr,
    output logic [N_GRP-1:0] pw_rise,
    output logic             fifo_nz
);
    typedef struct packed {
        logic [N_GRP-1:0][7:0] main;
        logic [7:0]            fifo;
        logic [7:0]            test;
    } regs_t;

    regs_t q, d;
    logic [7:0]    mem_q [SPAN];
    logic          mem_we;
    logic [MW-1:0] mem_wa;
    logic [7:0]    mem_wd;
    logic          in_chan, in_main;
    logic [GW-1:0] grp, midx;

    always_comb begin
        in_chan = addr < AW'(SPAN);
        in_main = (addr >= AW'(MAIN_BASE)) && (addr < AW'(MAIN_BASE + N_GRP));
        grp     = addr[MW-1:OW];
        midx    = addr[GW-1:0];

        d            = q;
        pw_rise      = '0;
        host_chan_wr = 1'b0;
        mem_we       = 1'b0;
        mem_wa       = fill_addr;
        mem_wd       = fill_data;

        if (wr_en) begin
            if (in_chan) begin
                if (!busy[grp]) begin
                    host_chan_wr = 1'b1;
                    mem_we       = 1'b1;
                    mem_wa       = addr[MW-1:0];
                    mem_wd       = wdata;
                end
            end else if (in_main) begin
                d.main[midx]  = wdata;
                pw_rise[midx] = wdata[0] && !q.main[midx][0];
            end else if (addr == AW'(FIFO_ADDR)) begin
                d.fifo = wdata;
            end else if (addr == AW'(TEST_ADDR)) begin
                d.test = wdata;
            end
        end
        if (!host_chan_wr && fill_we) mem_we = 1'b1;

        rdata = 8'h00;
        if (in_chan) begin
            if (busy[grp]) rdata = ecg_pkg::def_byte(int'(addr[OW-1:0]), CH_BYTES);
            else           rdata = mem_q[addr[MW-1:0]];
        end else if (in_main) begin
            rdata = q.main[midx];
        end else if (addr == AW'(FIFO_ADDR)) begin
            rdata = q.fifo;
        end else if (addr == AW'(TEST_ADDR)) begin
            rdata = q.test;
        end
        fifo_nz = q.fifo != 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_wa] <= mem_wd;
    end

    a_r8_fill_only_busy_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !host_chan_wr) |-> busy[fill_addr[MW-1:OW]]);
endmodule

// File: rtl/ecg_init_ctrl.sv
module ecg_init_ctrl #(
    parameter int N_GRP    = ecg_pkg::N_GRP,
    parameter int CH_BYTES = ecg_pkg::CH_BYTES,
    parameter int AW       = ecg_pkg::AW,
    localparam int GRP_BYTES = 2 * CH_BYTES,
    localparam int MW = $clog2(N_GRP) + $clog2(GRP_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             rdata_oe,
    output logic             irq,
    output logic             irq_oe,
    output logic [N_GRP-1:0] coef_clr,
    output logic [N_GRP-1:0] busy
);
    logic [N_GRP-1:0] pw_rise;
    logic             host_chan_wr;
    logic             fill_we;
    logic [MW-1:0]    fill_addr;
    logic [7:0]       fill_data;
    logic             fifo_nz;

    ecg_reg_bank #(.N_GRP(N_GRP), .CH_BYTES(CH_BYTES), .AW(AW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en && rst_n),
        .wdata        (wdata),
        .busy         (busy),
        .fill_we      (fill_we),
        .fill_addr    (fill_addr),
        .fill_data    (fill_data),
        .rdata        (rdata),
        .host_chan_wr (host_chan_wr),
        .pw_rise      (pw_rise),
        .fifo_nz      (fifo_nz)
    );

    ecg_fill_arb #(.N_GRP(N_GRP), .CH_BYTES(CH_BYTES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pw_rise   (pw_rise),
        .stall     (host_chan_wr),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_seq
        ecg_grp_seq u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .pw_rise     (pw_rise[g]),
            .frame_pulse (frame_pulse),
            .busy        (busy[g]),
            .coef_clr    (coef_clr[g])
        );
    end

    assign rdata_oe = rst_n && rd_en;
    assign irq_oe   = rst_n;
    assign irq      = fifo_nz;
endmodule

// File: tb/ecg_init_ctrl_tb.sv
module ecg_init_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 16;
    localparam int SPAN = 1024;
    localparam int FRAME_IDLE = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_pulse = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe, irq, irq_oe;
    logic [15:0] coef_clr, busy;

    int nvec = 0, nfail = 0;
    bit done = 0;

    logic [7:0] m_mem [SPAN];
    logic [7:0] m_main [NG];
    logic [7:0] m_fifo = 0, m_test = 0;
    logic [15:0] m_busy = 0;
    int          m_fc [NG];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecg_init_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .irq(irq), .irq_oe(irq_oe),
        .coef_clr(coef_clr), .busy(busy)
    );

    function automatic logic [7:0] dflt(int off);
        case (off % 32)
            0: return 8'h01;
            1: return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(int a);
        if (a < SPAN) return m_busy[a / 64] ? dflt(a % 64) : m_mem[a];
        if (a < SPAN + NG) return m_main[a - SPAN];
        if (a == SPAN + NG) return m_fifo;
        if (a == SPAN + NG + 1) return m_test;
        return 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(int a, logic [7:0] dv);
        logic [15:0] rise = '0;
        @(negedge clk);
        addr = 16'(a); wdata = dv; wr_en = 1'b1;
        if (a < SPAN) begin
            if (!m_busy[a / 64]) m_mem[a] = dv;
        end else if (a < SPAN + NG) begin
            int g = a - SPAN;
            if (dv[0] && !m_main[g][0]) begin
                rise[g] = 1'b1;
                m_busy[g] = 1'b1;
                m_fc[g] = 0;
                for (int k = 0; k < 64; k++) m_mem[g*64 + k] = dflt(k);
            end
            m_main[g] = dv;
        end else if (a == SPAN + NG) m_fifo = dv;
        else if (a == SPAN + NG + 1) m_test = dv;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 coef_clr after write", coef_clr, rise);
        check("R5/R9 busy after write", busy, m_busy);
        if (rise != 0) begin
            @(negedge clk);
            check("R5 coef_clr one cycle", coef_clr, 16'h0);
        end
    endtask

    task automatic bus_rd(int a, string req);
        @(negedge clk);
        addr = 16'(a); rd_en = 1'b1;
        #1;
        check(req, rdata, exp_read(a));
        check("R3 rdata_oe follows rd_en", rdata_oe, 1'b1);
        check("R4 irq vs fifo", irq, m_fifo != 0);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic frame();
        repeat (FRAME_IDLE) @(negedge clk);
        frame_pulse = 1'b1;
        for (int g = 0; g < NG; g++) if (m_busy[g]) begin
            m_fc[g]++;
            if (m_fc[g] == 2) m_busy[g] = 1'b0;
        end
        @(negedge clk);
        frame_pulse = 1'b0;
        check("R6 busy after frame", busy, m_busy);
    endtask

    task automatic read_group(int g, string req);
        for (int k = 0; k < 64; k++) bus_rd(g*64 + k, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7);
        for (int i = 0; i < NG; i++) begin m_main[i] = 0; m_fc[i] = 0; end
        for (int i = 0; i < SPAN; i++) m_mem[i] = 0;
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 rdata_oe low in reset", rdata_oe, 1'b0);
        check("R3 irq_oe low in reset", irq_oe, 1'b0);
        rd_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 irq_oe high", irq_oe, 1'b1);
        check("R2 busy zero", busy, 16'h0);
        check("R2 coef_clr zero", coef_clr, 16'h0);
        for (int a = SPAN; a < SPAN + NG + 2; a++) bus_rd(a, "R2 reset value");

        // Bring all groups into a known state (R11: all at once).
        for (int g = 0; g < NG; g++) bus_wr(SPAN + g, 8'h01);
        bus_rd(0, "R8 default during busy");
        bus_wr(5, 8'hAA);
        bus_rd(5, "R8 write ignored while busy");
        frame();
        frame();
        for (int g = 0; g < NG; g++) read_group(g, "R11 R7 defaults after init");

        // R12 idle read-back
        bus_wr(3*64 + 40, 8'h5C);
        bus_wr(3*64 + 2, 8'hC3);
        bus_rd(3*64 + 40, "R12 readback");
        bus_rd(3*64 + 2, "R1 R12 readback");

        // R9 repeated 1 and fall to 0
        bus_wr(SPAN + 3, 8'h03);
        bus_wr(SPAN + 3, 8'h00);
        bus_rd(3*64 + 40, "R9 bytes kept after fall");

        // R10 restart inside busy window
        bus_wr(SPAN + 3, 8'h01);
        frame();
        bus_wr(SPAN + 3, 8'h00);
        bus_wr(SPAN + 3, 8'h01);
        frame();
        check("R10 still busy after one frame post-restart", busy[3], 1'b1);
        frame();
        read_group(3, "R10 R7 defaults after restart");

        // R1 reserved, R4 irq
        bus_wr(16'h0412, 8'h77);
        bus_wr(16'hFFFF, 8'h11);
        bus_rd(16'h0412, "R1 reserved reads zero");
        bus_rd(16'hFFFF, "R1 reserved reads zero");
        bus_wr(SPAN + NG, 8'h02);
        bus_rd(SPAN + NG, "R4 fifo value");
        bus_wr(SPAN + NG, 8'h00);
        bus_rd(SPAN + NG + 1, "R4 irq low again");

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 100);
            if (r < 35)      bus_wr(int'($urandom % SPAN), 8'($urandom));
            else if (r < 57) bus_rd(int'($urandom % SPAN), "R8 R12 random channel read");
            else if (r < 64) bus_wr(SPAN + int'($urandom % NG), 8'($urandom));
            else if (r < 72) bus_rd(SPAN + int'($urandom % (NG + 4)), "R1 random control read");
            else if (r < 76) bus_wr(SPAN + NG + int'($urandom % 2), 8'($urandom % 4));
            else if (r < 78) frame();
            else if (r < 80) bus_wr(16'h0412 + int'($urandom % 64), 8'($urandom));
            else             bus_rd(int'($urandom % SPAN), "R7 R8 random channel read");
        end
        frame();
        frame();
        for (int g = 0; g < NG; g++) read_group(g, "R7 R12 final sweep");
        finish_run();
    end
endmodule